// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block drives the readout of one line from a three-colour linear CCD whose colours are each split across an odd and an even output. All of its outputs come from one fast system clock.

Each line starts with a charge-transfer phase. The shift clocks are held still while the transfer-gate pulse fires. Reset and clamp stay quiet for the whole of this phase. The shifting phase follows. In it the two complementary shift clocks run with a programmable half-period. A last-stage copy of the second phase runs with them. Each shift period can carry a reset-gate pulse and, in bit-clamp mode, a clamp pulse right after the reset. In line-clamp mode the clamp instead fires once per line, on the first optical-black pixel. A region tag tells a downstream sampler which kind of cell is being shifted out. A one-tick strobe marks the start of each line.

All pulse widths and the line length are given in system-clock ticks. Inputs are taken only at line boundaries, so every line runs with one consistent configuration. Lines never end before every cell has been shifted. A longer programmed length adds flush shifts at the end of the line.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is held, `o_phi1` is 1. `o_phi2`, `o_phi2_last`, `o_rst_gate`, `o_clamp`, `o_tgate` and `o_sol` are 0, and `o_region` is 2'b00.
- R2: During shifting, each shift period lasts 2×H ticks, where H is the latched half-period. `o_phi1` is high for the first H ticks and low for the last H ticks. `o_phi2` is its complement, and `o_phi2_last` equals `o_phi2` on every tick.
- R3: A line opens with a transfer phase of G + W + G ticks, where G is the gap and W the gate width. `o_phi1` stays high and `o_phi2` stays low throughout. `o_tgate` is high exactly on ticks G to G+W-1. Shifting starts on the next tick.
- R4: `o_rst_gate` and `o_clamp` are 0 on every tick of the transfer phase.
- R5: `o_rst_gate` is high for the first `i_rst_ticks` ticks of every shift period.
- R6: In bit-clamp mode (`i_line_clamp`=0), `o_clamp` is high on the `i_clp_ticks` ticks that follow the reset window of every shift period, cut off at the end of the period.
- R7: In line-clamp mode (`i_line_clamp`=1), `o_clamp` is high only during the first `i_clp_ticks` ticks of shift period number DUMMY_CNT (the first optical-black cell), cut off at the end of that period. It is low at all other times in the line.
- R8: `o_region` tags shift period p as follows. Dummy (2'b00) for p below DUMMY_CNT, then optical black (2'b01) for OB_CNT periods, then invalid (2'b10) for INV_CNT periods, then valid (2'b11) for VALID_CNT periods, then invalid (2'b10) for INV_CNT periods. It reads 2'b00 during the transfer phase and for any flush period after the pixel map.
- R9: `o_sol` is high for exactly one tick: the first tick of each transfer phase.
- R10: The shift phase has N periods, with N = max(TOTAL, ceil((L − X)/(2H))). Here TOTAL is the number of cells in the map, L is `i_line_ticks` and X is the transfer length. The next `o_sol` comes right after the last period.
- R11: Configuration inputs are latched on the tick a line starts. Changing them in mid-line has no effect on that line.
- R12: A zero half-period, gate width or gap is latched as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_line_clamp | input | 1 | 1 selects one clamp per line, 0 selects one clamp per pixel |
| i_half_ticks | input | 8 | Shift clock half-period in ticks |
| i_rst_ticks | input | 8 | Reset-gate pulse width in ticks |
| i_clp_ticks | input | 8 | Clamp pulse width in ticks |
| i_tg_ticks | input | TW | Transfer-gate pulse width in ticks |
| i_gap_ticks | input | TW | Settle time before and after the transfer gate |
| i_line_ticks | input | LW | Requested line length in ticks |
| o_phi1 | output | 1 | Shift clock phase 1 |
| o_phi2 | output | 1 | Shift clock phase 2 |
| o_phi2_last | output | 1 | Last-stage shift clock |
| o_rst_gate | output | 1 | Reset-gate pulse |
| o_clamp | output | 1 | Clamp pulse |
| o_tgate | output | 1 | Transfer-gate pulse |
| o_region | output | 2 | Cell region tag of the current shift period |
| o_sol | output | 1 | Start-of-line strobe |

## Verification
The hardest case to reach from the ports is a configuration change inside a running line. It has to land after the line has latched its settings and before the line ends. The bench rewrites every input a few ticks into a checked line and compares that whole line against the old settings. The next line, which latches the rewritten values, is skipped before new settings are applied. Flush extension and line-clamp truncation are reached by choosing a line length past the minimum and a clamp width longer than one shift period.

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
  parameter int DUMMY_CNT = 13,
  parameter int OB_CNT    = 48,
  parameter int INV_CNT   = 3,
  parameter int VALID_CNT = 3750,
  parameter int TW        = 16,
  parameter int LW        = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_line_clamp,
  input  logic [7:0]    i_half_ticks,
  input  logic [7:0]    i_rst_ticks,
  input  logic [7:0]    i_clp_ticks,
  input  logic [TW-1:0] i_tg_ticks,
  input  logic [TW-1:0] i_gap_ticks,
  input  logic [LW-1:0] i_line_ticks,
  output logic          o_phi1,
  output logic          o_phi2,
  output logic          o_phi2_last,
  output logic          o_rst_gate,
  output logic          o_clamp,
  output logic          o_tgate,
  output logic [1:0]    o_region,
  output logic          o_sol
);
  localparam int OB_END  = DUMMY_CNT + OB_CNT;
  localparam int IV1_END = OB_END + INV_CNT;
  localparam int VAL_END = IV1_END + VALID_CNT;
  localparam int TOTAL   = VAL_END + INV_CNT;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_SHIFT} state_t;
  state_t st;

  logic [LW-1:0] tick, pix;
  logic [8:0]    sub;
  logic [7:0]    half_q, rst_q, clp_q;
  logic [TW-1:0] tgw_q, gap_q;
  logic [LW-1:0] len_q;
  logic          mode_q;

  logic [8:0]    per_last;
  logic [TW+1:0] xfer_last;
  logic [LW-1:0] tg_beg, tg_end;
  logic          period_end, line_done, load;

  assign per_last   = {half_q, 1'b0} - 9'd1;
  assign xfer_last  = {1'b0, gap_q, 1'b0} + {2'b0, tgw_q} - 1'b1;
  assign tg_beg     = LW'(gap_q);
  assign tg_end     = LW'({1'b0, gap_q} + {1'b0, tgw_q});
  assign period_end = (st == S_SHIFT) && (sub == per_last);
  assign line_done  = (pix >= LW'(TOTAL - 1)) && ({1'b0, tick} + 1'b1 >= {1'b0, len_q});
  assign load       = (st == S_IDLE) || (period_end && line_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 8'd1; rst_q <= '0; clp_q <= '0;
      tgw_q <= TW'(1); gap_q <= TW'(1); len_q <= '0; mode_q <= 1'b0;
    end else if (load) begin
      half_q <= (i_half_ticks == '0) ? 8'd1 : i_half_ticks;
      tgw_q  <= (i_tg_ticks == '0) ? TW'(1) : i_tg_ticks;
      gap_q  <= (i_gap_ticks == '0) ? TW'(1) : i_gap_ticks;
      rst_q  <= i_rst_ticks;
      clp_q  <= i_clp_ticks;
      len_q  <= i_line_ticks;
      mode_q <= i_line_clamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tick <= '0; sub <= '0; pix <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st <= S_XFER; tick <= '0;
        end
        S_XFER: begin
          tick <= tick + 1'b1;
          if (tick == LW'(xfer_last)) begin
            st <= S_SHIFT; sub <= '0; pix <= '0;
          end
        end
        default: begin
          if (period_end) begin
            sub <= '0;
            if (line_done) begin
              st <= S_XFER; tick <= '0;
            end else begin
              pix <= pix + 1'b1; tick <= tick + 1'b1;
            end
          end else begin
            sub <= sub + 1'b1; tick <= tick + 1'b1;
          end
        end
      endcase
    end
  end

  wire shifting = (st == S_SHIFT);
  wire [8:0] clp_end = {1'b0, rst_q} + {1'b0, clp_q};

  assign o_phi1      = !(shifting && (sub >= {1'b0, half_q}));
  assign o_phi2      = !o_phi1;
  assign o_phi2_last = o_phi2;
  assign o_tgate     = (st == S_XFER) && (tick >= tg_beg) && (tick < tg_end);
  assign o_rst_gate  = shifting && (sub < {1'b0, rst_q});
  assign o_clamp     = shifting && (mode_q ? ((pix == LW'(DUMMY_CNT)) && (sub < {1'b0, clp_q}))
                                           : ((sub >= {1'b0, rst_q}) && (sub < clp_end)));
  assign o_sol       = (st == S_XFER) && (tick == '0);

  always_comb begin
    o_region = 2'b00;
    if (shifting) begin
      if (pix < LW'(DUMMY_CNT))    o_region = 2'b00;
      else if (pix < LW'(OB_END))  o_region = 2'b01;
      else if (pix < LW'(IV1_END)) o_region = 2'b10;
      else if (pix < LW'(VAL_END)) o_region = 2'b11;
      else if (pix < LW'(TOTAL))   o_region = 2'b10;
    end
  end

  p_tg_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    o_tgate |-> (!o_rst_gate && !o_clamp));
  p_tg_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    o_tgate |-> (o_phi1 && !o_phi2_last));
  p_sol_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    o_sol |=> !o_sol);
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_region == 2'b11) |=> (o_region == 2'b11 || o_region == 2'b10));
  p_line_clamp_ob_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_clamp && mode_q) |-> (o_region == 2'b01));
  p_bit_clamp_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (o_clamp && !mode_q) |-> !o_rst_gate);
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !load) |=> ($stable(half_q) && $stable(len_q) && $stable(mode_q)));
endmodule

// File: tb/test_ccd_line_timer.sv
module test_ccd_line_timer;
  localparam int D = 13, OB = 48, INV = 3, VAL = 40;
  localparam int TOTAL = D + OB + INV + VAL + INV;
  localparam int TW = 16, LW = 24;

  logic clk = 0, rst_n = 0;
  logic i_line_clamp = 0;
  logic [7:0] i_half_ticks = 2, i_rst_ticks = 1, i_clp_ticks = 1;
  logic [TW-1:0] i_tg_ticks = 3, i_gap_ticks = 2;
  logic [LW-1:0] i_line_ticks = 0;
  logic o_phi1, o_phi2, o_phi2_last, o_rst_gate, o_clamp, o_tgate, o_sol;
  logic [1:0] o_region;

  int total = 0, fails = 0;
  bit bad [1:12];
  string msg [1:12];

  always #2 clk = ~clk;

  ccd_line_timer #(.DUMMY_CNT(D), .OB_CNT(OB), .INV_CNT(INV), .VALID_CNT(VAL),
                   .TW(TW), .LW(LW)) i_ccd_line_timer (
    .clk, .rst_n, .i_line_clamp, .i_half_ticks, .i_rst_ticks, .i_clp_ticks,
    .i_tg_ticks, .i_gap_ticks, .i_line_ticks, .o_phi1, .o_phi2, .o_phi2_last,
    .o_rst_gate, .o_clamp, .o_tgate, .o_region, .o_sol);

  task automatic cmp(int rq, int t, string what, logic [1:0] got, logic [1:0] exp);
    if (got !== exp && !bad[rq]) begin
      bad[rq] = 1;
      msg[rq] = $sformatf("%s at tick %0d: got %0d expected %0d", what, t, got, exp);
    end
  endtask

  task automatic report(int rq, string tag, string name);
    total++;
    if (bad[rq]) begin
      fails++;
      $display("FAIL %s [%s] %s", tag, name, msg[rq]);
    end
  endtask

  function automatic logic [1:0] exp_region(int p);
    if (p < D) return 2'b00;
    if (p < D + OB) return 2'b01;
    if (p < D + OB + INV) return 2'b10;
    if (p < D + OB + INV + VAL) return 2'b11;
    if (p < TOTAL) return 2'b10;
    return 2'b00;
  endfunction

  task automatic set_cfg(bit m, int h, int r, int c, int w, int g, int len);
    i_line_clamp = m; i_half_ticks = 8'(h); i_rst_ticks = 8'(r); i_clp_ticks = 8'(c);
    i_tg_ticks = TW'(w); i_gap_ticks = TW'(g); i_line_ticks = LW'(len);
  endtask

  // Waits for the next line start and checks the whole line against the settings given.
  task automatic check_line(string name, bit m, int h, int r, int c, int w, int g, int len,
                            bit scramble);
    int hh, ww, gg, per, xl, np, L;
    hh = (h == 0) ? 1 : h;   // R12 zero fields become 1
    ww = (w == 0) ? 1 : w;
    gg = (g == 0) ? 1 : g;
    per = 2 * hh;
    xl = 2 * gg + ww;
    np = TOTAL;
    if (len > xl && (len - xl + per - 1) / per > np) np = (len - xl + per - 1) / per;
    L = xl + per * np;
    for (int k = 1; k <= 12; k++) bad[k] = 0;
    @(negedge clk);
    while (!o_sol) @(negedge clk);
    for (int t = 0; t < L; t++) begin
      if (scramble && t == 5) set_cfg(!m, 7, 5, 9, 40, 30, 9000); // R11 mid-line rewrite
      cmp(9, t, "sol", o_sol, t == 0);                            // R9
      if (t < xl) begin
        cmp(3, t, "phi1 in transfer", o_phi1, 1);                 // R3
        cmp(3, t, "phi2 in transfer", o_phi2, 0);                 // R3
        cmp(3, t, "tgate", o_tgate, (t >= gg && t < gg + ww));    // R3
        cmp(4, t, "rst_gate in transfer", o_rst_gate, 0);         // R4
        cmp(4, t, "clamp in transfer", o_clamp, 0);               // R4
        cmp(8, t, "region in transfer", o_region, 0);             // R8
      end else begin
        int s, p, sb;
        s = t - xl; p = s / per; sb = s % per;
        cmp(2, t, "phi1", o_phi1, sb < hh);                       // R2
        cmp(2, t, "phi2", o_phi2, sb >= hh);                      // R2
        cmp(2, t, "phi2_last", o_phi2_last, sb >= hh);            // R2
        cmp(3, t, "tgate in shift", o_tgate, 0);                  // R3
        cmp(5, t, "rst_gate", o_rst_gate, sb < r);                // R5
        if (m) cmp(7, t, "line clamp", o_clamp, (p == D && sb < c));      // R7
        else   cmp(6, t, "bit clamp", o_clamp, (sb >= r && sb < r + c));  // R6
        cmp(8, t, "region", o_region, exp_region(p));             // R8
        if (p >= TOTAL) cmp(10, t, "flush region", o_region, 0);  // R10
      end
      @(negedge clk);
    end
    cmp(10, L, "next line start", o_sol, 1);                      // R10
    report(2, "R2", name); report(3, "R3", name); report(4, "R4", name);
    report(5, "R5", name); report(8, "R8", name); report(9, "R9", name);
    report(10, "R10", name);
    if (m) report(7, "R7", name); else report(6, "R6", name);
    if (scramble) begin bad[11] = bad[2] | bad[3] | bad[5] | bad[6] | bad[7] | bad[8] | bad[10];
      msg[11] = "line disturbed by mid-line input change"; report(11, "R11", name); end
    if (h == 0 || w == 0 || g == 0) begin bad[12] = bad[2] | bad[3] | bad[10];
      msg[12] = "zero field not treated as one"; report(12, "R12", name); end
  endtask

  task automatic test_reset();
    @(negedge clk);
    total++;
    if ({o_phi1, o_phi2, o_phi2_last, o_rst_gate, o_clamp, o_tgate, o_sol, o_region} !== 9'b100000000) begin
      fails++;
      $display("FAIL R1 reset outputs got %b expected 100000000",
               {o_phi1, o_phi2, o_phi2_last, o_rst_gate, o_clamp, o_tgate, o_sol, o_region});
    end
  endtask

  task automatic test_bit_min();     check_line("bit min", 0, 2, 1, 1, 3, 2, 0, 0); endtask
  task automatic test_bit_wide();    set_cfg(0, 3, 2, 3, 5, 1, 0);
                                     check_line("bit wide", 0, 3, 2, 3, 5, 1, 0, 0); endtask
  task automatic test_line_mode();   set_cfg(1, 2, 1, 3, 4, 2, 0);
                                     check_line("line clamp", 1, 2, 1, 3, 4, 2, 0, 0); endtask
  task automatic test_line_trunc();  set_cfg(1, 2, 1, 10, 2, 3, 0);
                                     check_line("line clamp cut", 1, 2, 1, 10, 2, 3, 0, 0); endtask
  task automatic test_flush();       set_cfg(0, 2, 1, 2, 3, 2, 7 + 4 * TOTAL + 37);
                                     check_line("flush", 0, 2, 1, 2, 3, 2, 7 + 4 * TOTAL + 37, 0); endtask
  task automatic test_zero_fields(); set_cfg(0, 0, 0, 0, 0, 0, 0);
                                     check_line("zero fields", 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic test_midline();     set_cfg(0, 2, 1, 1, 3, 2, 0);
                                     check_line("mid-line change", 0, 2, 1, 1, 3, 2, 0, 1);
                                     set_cfg(0, 2, 1, 1, 3, 2, 0);
                                     @(negedge clk); while (!o_sol) @(negedge clk); endtask

  initial begin
    set_cfg(0, 2, 1, 1, 3, 2, 0);
    test_reset();
    @(negedge clk); rst_n = 1;
    test_bit_min();
    test_bit_wide();
    test_line_mode();
    test_line_trunc();
    test_flush();
    test_midline();
    test_zero_fields();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule